// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Packed-BCD Mode

This unit performs one arithmetic, logic, compare or shift step for an 8-bit accumulator machine. Each operation takes an operation code, the accumulator value, a second operand and the incoming status byte. It returns an 8-bit result and an outgoing status byte in which the negative, overflow, zero and carry flags have been updated. Add and subtract work on plain binary values. When the decimal bit of the incoming status byte is set, they work on two packed BCD digits instead. Subtraction always runs through the same adder as addition, with the operand inverted. In decimal mode, each direction then applies its own nibble correction.

A caller presents the inputs and raises `go` for one clock. The unit samples the inputs on that rising edge and loads its result and status registers. A two-state output controller then raises `done` for the following cycle. The controller sits in `ST_IDLE` until `go` is seen, which is the *accept* transition into `ST_DONE`. From `ST_DONE`, another `go` takes the *re-accept* transition back into `ST_DONE`. Without `go`, it takes the *retire* transition back to `ST_IDLE`. The result and status registers hold their values whenever `go` is low.

Top module: `alu8_dec`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `go`, `result` is 0x00, `flags_out` is 0x20 and `done` is 0.
- R2: The status bytes use this layout: bit7 N, bit6 V, bit5 reads 1, bit4 B, bit3 D, bit2 I, bit1 Z, bit0 C. Every operation copies bits 4, 3 and 2 from `flags_in` to `flags_out`, and bit5 of `flags_out` is always 1.
- R3: Op 0 with D=0 (binary add) produces A+M+C. C is set when the 9-bit sum exceeds 0xFF. V is set when both inputs have the same sign and the result sign differs from it. Examples: 0x50+0x50 gives 0xA0 with V=1, and 0xD0+0xD0 gives 0xA0 with C=1 and V=0.
- R4: Op 1 with D=0 (binary subtract) produces A-M-(1-C). C is set when no borrow occurs. V is set when the operands differ in sign and the result sign differs from A. Example: 0x00-0x01 with C=1 gives 0xFF with C=0.
- R5: Op 0 with D=1 (decimal add) works nibble by nibble. If the low digit sum plus carry is above 9, 6 is added to it and one is carried into the high digit. If the high digit is then above 9, 6 is added to it, and C is the carry out of that digit. V is taken from the value formed before the high-digit correction. Example: 0x99+0x01 with C=0 gives 0x00 with C=1.
- R6: Op 1 with D=1 (decimal subtract) takes the binary difference and corrects it. It subtracts 0x06 when the low digit borrowed, and 0x60 when the whole byte borrowed. C and V are the same as in binary subtract. Example: 0x00-0x01 with C=1 gives 0x99 with C=0.
- R7: For ops 0 to 4 and 6 to 9, Z is set exactly when `result` is 0x00, and N equals bit 7 of `result`.
- R8: Ops 2, 3 and 4 (AND, OR, XOR of A and M) change only N and Z. C and V keep their input values.
- R9: Op 6 shifts A left: bit 7 goes to C and a 0 enters bit 0. Op 7 shifts A right: bit 0 goes to C and a 0 enters bit 7. Op 8 rotates left and op 9 rotates right; each puts the old C into the vacated bit. V is unchanged by all four.
- R10: Op 10 is excluded from this line and covered by R11. Op 5 (compare) leaves `result` equal to A. It sets C when A ≥ M as unsigned values, takes Z and N from A-M, leaves V unchanged and ignores D.
- R11: Op codes 10 to 15 have no effect. `result` equals A, and N, V, Z and C equal their input values.
- R12: Outputs update on the rising edge that samples `go` high. `done` is 1 in exactly the cycle after each sampled `go`. While `go` is low, `result` and `flags_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Sample inputs and start an operation this edge |
| op_code | input | 4 | Operation select (0 to 9 defined, 10 to 15 no effect) |
| acc_in | input | 8 | Accumulator value A |
| opd_in | input | 8 | Second operand M |
| flags_in | input | 8 | Incoming status byte in the R2 layout |
| result | output | 8 | Registered result |
| flags_out | output | 8 | Registered outgoing status byte |
| done | output | 1 | High the cycle after a sampled `go` |

## Verification
Every result and status byte is due one register stage after the edge that samples `go`. The bench drives inputs on the falling edge, with `go` high. It lets one rising edge pass and reads `result`, `flags_out` and `done` on the next falling edge, half a cycle after they were loaded. The bench lowers `go` before it reads the outputs. For the hold checks, it then changes the inputs while `go` stays low, waits two more cycles and reads again. The unchanged outputs and the low `done` show that nothing was loaded.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NIB = DW / 2;

    // Operation codes; values 10..15 are defined as no-operation
    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_SUB = 4'd1;
    localparam logic [3:0] OP_AND = 4'd2;
    localparam logic [3:0] OP_OR  = 4'd3;
    localparam logic [3:0] OP_XOR = 4'd4;
    localparam logic [3:0] OP_CMP = 4'd5;
    localparam logic [3:0] OP_SHL = 4'd6;
    localparam logic [3:0] OP_SHR = 4'd7;
    localparam logic [3:0] OP_ROL = 4'd8;
    localparam logic [3:0] OP_ROR = 4'd9;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } out_state_e;

    // Status byte bit positions
    localparam int FB_C   = 0;
    localparam int FB_Z   = 1;
    localparam int FB_I   = 2;
    localparam int FB_D   = 3;
    localparam int FB_B   = 4;
    localparam int FB_ONE = 5;
    localparam int FB_V   = 6;
    localparam int FB_N   = 7;

    function automatic logic [7:0] pack_status(
        input logic n, input logic v, input logic b, input logic d,
        input logic i, input logic z, input logic c);
        return {n, v, 1'b1, b, d, i, z, c};
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    input  logic          dec_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);

    logic [DW-1:0] b_eff;
    logic [DW:0]   bin;
    logic          lo_half;
    logic [NIB:0]  dlo;
    logic [NIB:0]  dhi;
    logic          dhc;
    logic [DW-1:0] mid;
    logic [DW-1:0] sub_fix;

    always_comb begin
        // Shared binary adder; subtract feeds the inverted operand
        b_eff   = sub_i ? ~b_i : b_i;
        bin     = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
        lo_half = ({1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]}
                   + {{NIB{1'b0}}, cin_i}) > 5'd15;

        // Decimal add: per-digit adjust
        dlo = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
        dhc = (dlo > 5'd9);
        if (dhc) dlo = dlo + 5'd6;
        dhi = {1'b0, a_i[DW-1:NIB]} + {1'b0, b_i[DW-1:NIB]} + {{NIB{1'b0}}, dhc};
        mid = {dhi[NIB-1:0], dlo[NIB-1:0]};
        if (dhi > 5'd9) dhi = dhi + 5'd6;

        // Decimal subtract: correct the binary difference
        sub_fix = bin[DW-1:0] - (lo_half ? 8'h00 : 8'h06) - (bin[DW] ? 8'h00 : 8'h60);

        if (dec_i && !sub_i) begin
            sum_o  = {dhi[NIB-1:0], dlo[NIB-1:0]};
            cout_o = dhi[NIB];
            ovf_o  = ~(a_i[DW-1] ^ b_i[DW-1]) & (a_i[DW-1] ^ mid[DW-1]);
        end else if (dec_i) begin
            sum_o  = sub_fix;
            cout_o = bin[DW];
            ovf_o  = ~(a_i[DW-1] ^ b_eff[DW-1]) & (a_i[DW-1] ^ bin[DW-1]);
        end else begin
            sum_o  = bin[DW-1:0];
            cout_o = bin[DW];
            ovf_o  = ~(a_i[DW-1] ^ b_eff[DW-1]) & (a_i[DW-1] ^ bin[DW-1]);
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);

    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_SHL: begin
                res_o  = {a_i[DW-2:0], 1'b0};
                cout_o = a_i[DW-1];
            end
            OP_SHR: begin
                res_o  = {1'b0, a_i[DW-1:1]};
                cout_o = a_i[0];
            end
            OP_ROL: begin
                res_o  = {a_i[DW-2:0], cin_i};
                cout_o = a_i[DW-1];
            end
            OP_ROR: begin
                res_o  = {cin_i, a_i[DW-1:1]};
                cout_o = a_i[0];
            end
            default: begin
                res_o  = a_i;
                cout_o = cin_i;
            end
        endcase
    end

endmodule

// File: rtl/alu8_dec.sv
module alu8_dec
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opd_in,
    input  logic [7:0]    flags_in,
    output logic [DW-1:0] result,
    output logic [7:0]    flags_out,
    output logic          done
);

    out_state_e    state_q, state_d;

    logic          as_sub, as_dec, as_cin;
    logic [DW-1:0] as_sum;
    logic          as_cout, as_ovf;
    logic [DW-1:0] lg_res;
    logic          lg_cout;

    logic [DW-1:0] nxt_res;
    logic [DW-1:0] nz_src;
    logic          nxt_c, nxt_v, nxt_n, nxt_z;
    logic          keep_nz;
    logic          flag_rsvd_unused;

    assign flag_rsvd_unused = flags_in[FB_ONE];

    always_comb begin
        as_sub = (op_code == OP_SUB) || (op_code == OP_CMP);
        as_dec = flags_in[FB_D] && (op_code != OP_CMP);
        as_cin = (op_code == OP_CMP) ? 1'b1 : flags_in[FB_C];
    end

    alu8_addsub u_addsub (
        .a_i   (acc_in),
        .b_i   (opd_in),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .dec_i (as_dec),
        .sum_o (as_sum),
        .cout_o(as_cout),
        .ovf_o (as_ovf)
    );

    alu8_logic u_logic (
        .op_i  (op_code),
        .a_i   (acc_in),
        .b_i   (opd_in),
        .cin_i (flags_in[FB_C]),
        .res_o (lg_res),
        .cout_o(lg_cout)
    );

    // Result and flag selection
    always_comb begin
        nxt_res = acc_in;
        nz_src  = acc_in;
        nxt_c   = flags_in[FB_C];
        nxt_v   = flags_in[FB_V];
        keep_nz = 1'b0;
        unique case (op_code)
            OP_ADD, OP_SUB: begin
                nxt_res = as_sum;
                nz_src  = as_sum;
                nxt_c   = as_cout;
                nxt_v   = as_ovf;
            end
            OP_CMP: begin
                nxt_res = acc_in;
                nz_src  = as_sum;
                nxt_c   = as_cout;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res = lg_res;
                nz_src  = lg_res;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                nxt_res = lg_res;
                nz_src  = lg_res;
                nxt_c   = lg_cout;
            end
            default: keep_nz = 1'b1;
        endcase
        nxt_n = keep_nz ? flags_in[FB_N] : nz_src[DW-1];
        nxt_z = keep_nz ? flags_in[FB_Z] : (nz_src == '0);
    end

    // Output controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_DONE;
            ST_DONE: state_d = go ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            flags_out <= 8'h20;
        end else if (go) begin
            result    <= nxt_res;
            flags_out <= pack_status(nxt_n, nxt_v, flags_in[FB_B], flags_in[FB_D],
                                     flags_in[FB_I], nxt_z, nxt_c);
        end
    end

    assign done = (state_q == ST_DONE);

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(result) && $stable(flags_out)));

    // R12
    done_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);

    // R12
    no_done_without_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !done);

    // R2
    ctrl_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (flags_out[4:2] == $past(flags_in[4:2])) && flags_out[FB_ONE]);

    // R10
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code == OP_CMP) |=>
            (result == $past(acc_in)) && (flags_out[FB_V] == $past(flags_in[FB_V])));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code < 4'd10 && op_code != OP_CMP) |=>
            (flags_out[FB_Z] == (result == '0)) && (flags_out[FB_N] == result[DW-1]));

endmodule

// File: tb/alu8_dec_tb.sv
`timescale 1ns/1ps
module alu8_dec_tb;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0, opd_in = '0, flags_in = '0;
    logic [7:0] result, flags_out;
    logic       done;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    alu8_dec u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .op_code(op_code),
        .acc_in(acc_in), .opd_in(opd_in), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .done(done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // Reference model: returns {status, result}
    function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
        int c, d, r, lo, hi, mid, t, br;
        logic nc, nv, nn, nz;
        logic [7:0] res, zsrc;
        c = int'(f[0]); d = int'(f[3]); br = 1 - c;
        nc = f[0]; nv = f[6]; nn = f[7]; nz = f[1];
        res = a; zsrc = a;
        case (op)
            4'd0: begin
                if (d == 1) begin
                    lo = (a & 15) + (b & 15) + c;
                    hi = (a >> 4) + (b >> 4);
                    if (lo > 9) begin lo += 6; hi += 1; end
                    mid = ((hi << 4) + (lo & 15)) & 255;
                    nv = ((~(a ^ b)) & (a ^ mid[7:0]) & 8'h80) != 0;
                    if (hi > 9) hi += 6;
                    nc = hi > 15;
                    r = ((hi << 4) | (lo & 15)) & 255;
                end else begin
                    r = int'(a) + int'(b) + c;
                    nc = r > 255;
                    r = r & 255;
                    nv = ((a ^ r[7:0]) & (b ^ r[7:0]) & 8'h80) != 0;
                end
                res = r[7:0]; zsrc = res;
            end
            4'd1: begin
                t = int'(a) - int'(b) - br;
                nc = t >= 0;
                r = t & 255;
                nv = ((a ^ b) & (a ^ r[7:0]) & 8'h80) != 0;
                if (d == 1) begin
                    if (int'(a & 15) < int'(b & 15) + br) t -= 6;
                    if (!nc) t -= 8'h60;
                    r = t & 255;
                end
                res = r[7:0]; zsrc = res;
            end
            4'd2: begin res = a & b; zsrc = res; end
            4'd3: begin res = a | b; zsrc = res; end
            4'd4: begin res = a ^ b; zsrc = res; end
            4'd5: begin
                nc = a >= b;
                zsrc = a - b;
                res = a;
            end
            4'd6: begin nc = a[7]; res = a << 1; zsrc = res; end
            4'd7: begin nc = a[0]; res = a >> 1; zsrc = res; end
            4'd8: begin nc = a[7]; res = {a[6:0], f[0]}; zsrc = res; end
            4'd9: begin nc = a[0]; res = {f[0], a[7:1]}; zsrc = res; end
            default: ;
        endcase
        if (op < 4'd10) begin
            nn = zsrc[7];
            nz = (zsrc == 8'h00);
        end
        return {pack_status(nn, nv, f[4], f[3], f[2], nz, nc), res};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic dflag);
        case (op)
            4'd0: return dflag ? "R5" : "R3";
            4'd1: return dflag ? "R6" : "R4";
            4'd2, 4'd3, 4'd4: return "R8";
            4'd5: return "R10";
            4'd6, 4'd7, 4'd8, 4'd9: return "R9";
            default: return "R11";
        endcase
    endfunction

    // Drive on a falling edge, let one rising edge sample, read at next falling edge
    task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] f, input string tag);
        logic [15:0] exp;
        op_code = op; acc_in = a; opd_in = b; flags_in = f; go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        exp = model(op, a, b, f);
        chk(tag, "result", result, exp[7:0]);
        chk(tag, "flags", flags_out, exp[15:8]);
    endtask

    function automatic logic [7:0] rand_bcd();
        int v;
        v = $urandom_range(0, 99);
        return 8'((v / 10) << 4 | (v % 10));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] held_r, held_f;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "result", result, 8'h00);
        chk("R1", "flags", flags_out, 8'h20);
        chk("R1", "done", {7'b0, done}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "flags after release", flags_out, 8'h20);

        // R5, R6 decimal corners
        run_op(4'd0, 8'h99, 8'h01, 8'h08, "R5");
        chk("R5", "value", result, 8'h00);
        chk("R5", "carry", {7'b0, flags_out[0]}, 8'h01);
        chk("R12", "done", {7'b0, done}, 8'h01);
        run_op(4'd1, 8'h00, 8'h01, 8'h09, "R6");
        chk("R6", "value", result, 8'h99);
        chk("R6", "carry", {7'b0, flags_out[0]}, 8'h00);
        run_op(4'd0, 8'h58, 8'h46, 8'h09, "R5");
        // R3 binary add corners
        run_op(4'd0, 8'h50, 8'h50, 8'h00, "R3");
        chk("R3", "overflow", {7'b0, flags_out[6]}, 8'h01);
        run_op(4'd0, 8'hD0, 8'hD0, 8'h00, "R3");
        chk("R3", "carry/overflow", {6'b0, flags_out[6], flags_out[0]}, 8'h01);
        // R4 binary subtract
        run_op(4'd1, 8'h00, 8'h01, 8'h01, "R4");
        chk("R4", "value", result, 8'hFF);
        chk("R4", "carry", {7'b0, flags_out[0]}, 8'h00);
        // R7 zero result, R2 layout pass-through
        run_op(4'd4, 8'h5A, 8'h5A, 8'hD7, "R7");
        chk("R7", "zero flag", {7'b0, flags_out[1]}, 8'h01);
        run_op(4'd2, 8'h80, 8'hFF, 8'h00, "R2");
        chk("R2", "bit5 and ctrl bits", flags_out & 8'h3C, 8'h20);
        run_op(4'd3, 8'h01, 8'h02, 8'h1C, "R2");
        chk("R2", "ctrl bits", flags_out & 8'h3C, 8'h3C);
        // R9 shift edges
        run_op(4'd6, 8'h80, 8'h00, 8'h00, "R9");
        run_op(4'd9, 8'h01, 8'h00, 8'h01, "R9");
        chk("R9", "ror value", result, 8'h80);
        // R10 compare, decimal ignored, V kept
        run_op(4'd5, 8'h10, 8'h10, 8'h48, "R10");
        chk("R10", "equal flags", flags_out & 8'hC3, 8'h43);
        run_op(4'd5, 8'h05, 8'h06, 8'h09, "R10");
        // R11 unused codes
        run_op(4'd12, 8'h33, 8'h44, 8'hC3, "R11");
        chk("R11", "flags", flags_out, 8'hE3);

        // R12 hold while go low
        held_r = result; held_f = flags_out;
        op_code = 4'd0; acc_in = 8'h11; opd_in = 8'h22; flags_in = 8'h01;
        repeat (2) @(negedge clk);
        chk("R12", "held result", result, held_r);
        chk("R12", "held flags", flags_out, held_f);
        chk("R12", "done low", {7'b0, done}, 8'h00);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] op;
            logic [7:0] a, b, f;
            op = 4'($urandom_range(0, 15));
            f  = 8'($urandom);
            a  = 8'($urandom);
            b  = 8'($urandom);
            if (f[3] && op < 4'd2) begin
                a = rand_bcd();
                b = rand_bcd();
            end
            run_op(op, a, b, f, tag_of(op, f[3]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule